// File: doc/BRIEF.md
# LCD Timing Engine Power Sequencer

This block brings the timing engine of a display controller up and down in a fixed order: the pixel clock first, then horizontal and vertical synchronization, then the display power pin. Software drives two 3-bit strobe vectors. A one on a bit of the enable vector requests that stage. A one on the matching bit of the disable vector drops it. Software then polls a 3-bit status vector to learn whether the stage really is active before it moves to the next one.

Stages are interlocked. A stage is not raised unless the stage below it reports running. A stage is not dropped while the stage above it is still in use. The display power pin does not rise as soon as it is requested. It waits a programmable number of frames, counted on a frame-start pulse from the external timing generator.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, `pclk_en`, `sync_run`, `disp_out` and all three `status` bits are 0. Bit positions in `en_req`, `dis_req` and `status` are: bit 0 clock, bit 1 sync, bit 2 display.
- R2: An `en_req[0]` strobe sets `pclk_en` after the next clock edge. `status[0]` follows `pclk_en` one cycle later.
- R3: An `en_req[1]` strobe is ignored while `status[0]` is 0.
- R4: An accepted `en_req[1]` strobe sets `sync_run` after the next edge. `status[1]` follows `sync_run` one cycle later.
- R5: An `en_req[2]` strobe is ignored while `status[1]` is 0, including the cycle in which `sync_run` is already high but its status is not.
- R6: After an accepted `en_req[2]`, `disp_out` rises on the edge that samples the (G+1)-th `frame_start` pulse, where G is `guard_frames`. `status[2]` follows one cycle later.
- R7: With `guard_frames` = 0, the first `frame_start` pulse after the request raises `disp_out`.
- R8: A `dis_req[2]` strobe drops `disp_out` after the next edge and cancels any pending display request and its frame count.
- R9: A `dis_req[1]` strobe is ignored while `disp_out` is high or a display request is pending.
- R10: A `dis_req[0]` strobe is ignored while `sync_run` is high.
- R11: When the enable and disable bits of one stage are both set in the same cycle, the disable wins.
- R12: The sequence display-off, sync-off, clock-off returns every output and status bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 3 | Write-one-to-enable strobes (0 clock, 1 sync, 2 display) |
| dis_req | input | 3 | Write-one-to-disable strobes (same bit positions) |
| guard_frames | input | GW | Frame-start pulses to skip before the display pin rises |
| frame_start | input | 1 | One-cycle frame-start pulse from the timing generator |
| pclk_en | output | 1 | Pixel clock enable |
| sync_run | output | 1 | Synchronization running qualifier |
| disp_out | output | 1 | Display power pin |
| status | output | 3 | Stage active flags (0 clock, 1 sync, 2 display) |

## Verification
The hardest case to reach is a sync-disable strobe that arrives while a display request is pending. In that state the display pin is still low, so only the guard-time count protects the interlock. The stimulus sets a long guard time and issues the display request. It then sends the sync disable between frame pulses, before the count expires. A display request placed in the single cycle where `sync_run` is high but `status[1]` is still low exercises the status lag.

// File: rtl/lcd_pwr_pkg.sv
// Shared stage indices for the power sequencer.
// Assumes the strobe and status vectors share one bit layout.
package lcd_pwr_pkg;
    localparam int STG_N    = 3;
    localparam int IDX_CLK  = 0;
    localparam int IDX_SYNC = 1;
    localparam int IDX_DISP = 2;
endpackage

// File: rtl/lcd_stage_ctl.sv
// One interlocked on/off stage driven by enable and disable strobes.
// Assumes the strobes are single-cycle. The allow inputs come from the
// neighbouring stages. Disable has priority over enable.
module lcd_stage_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic dis_i,
    input  logic allow_en_i,
    input  logic allow_dis_i,
    output logic on_o,
    output logic sts_o
);
    // Stage output: disable first, then a permitted enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            on_o <= 1'b0;
        else if (dis_i && allow_dis_i)
            on_o <= 1'b0;
        else if (en_i && !dis_i && allow_en_i)
            on_o <= 1'b1;
    end

    // Status flag trails the stage output by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sts_o <= 1'b0;
        else
            sts_o <= on_o;
    end

    AST_STS_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        sts_o == $past(on_o)); // R2
    AST_EN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !allow_en_i && !on_o) |=> !on_o); // R3
    AST_DIS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_i && !allow_dis_i && on_o) |=> on_o); // R10
    AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && dis_i && allow_dis_i) |=> !on_o); // R11
endmodule

// File: rtl/lcd_disp_guard.sv
// Display power stage with a guard delay counted in frame-start pulses.
// Assumes frame_i is a one-cycle pulse. A request is accepted only while
// the sync status is set. Losing sync or a disable clears everything.
module lcd_disp_guard #(
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          dis_i,
    input  logic          sync_on_i,
    input  logic          sync_sts_i,
    input  logic          frame_i,
    input  logic [GW-1:0] guard_i,
    output logic          disp_o,
    output logic          disp_sts_o,
    output logic          pend_o
);
    logic [GW-1:0] frm_cnt;
    logic          clr;
    logic          tick;

    assign clr  = dis_i || !sync_on_i;
    assign tick = pend_o && frame_i && !disp_o;

    // Pending request flag, set by a permitted enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pend_o <= 1'b0;
        else if (en_i && sync_sts_i)
            pend_o <= 1'b1;
    end

    // Frame counter and display pin: the pin rises once the count meets the guard.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            frm_cnt <= '0;
            disp_o  <= 1'b0;
        end else if (tick) begin
            if (frm_cnt == guard_i)
                disp_o <= 1'b1;
            else
                frm_cnt <= frm_cnt + 1'b1;
        end
    end

    // Display status trails the pin by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            disp_sts_o <= 1'b0;
        else
            disp_sts_o <= disp_o;
    end

    AST_DISP_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        disp_o |-> sync_on_i); // R9
    AST_RISE_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_o) |-> $past(frame_i)); // R6
    AST_DISP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |=> !disp_o); // R8
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_o |-> (frm_cnt == '0)); // R8
    AST_DISP_STS: assert property (@(posedge clk) disable iff (!rst_n)
        disp_sts_o == $past(disp_o)); // R6
endmodule

// File: rtl/lcd_pwr_seq.sv
// Top of the timing engine power sequencer. Two generic stages (clock,
// sync) and the guarded display stage, wired with their interlocks.
// Assumes all strobes are synchronous to clk.
module lcd_pwr_seq
    import lcd_pwr_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STG_N-1:0] en_req,
    input  logic [STG_N-1:0] dis_req,
    input  logic [GW-1:0]    guard_frames,
    input  logic             frame_start,
    output logic             pclk_en,
    output logic             sync_run,
    output logic             disp_out,
    output logic [STG_N-1:0] status
);
    localparam int N_BASIC = STG_N - 1;

    logic [N_BASIC-1:0] allow_en;
    logic [N_BASIC-1:0] allow_dis;
    logic [N_BASIC-1:0] stg_on;
    logic [N_BASIC-1:0] stg_sts;
    logic               disp_pend;
    logic               disp_sts;

    // Interlocks between neighbouring stages.
    always_comb begin
        allow_en[IDX_CLK]   = 1'b1;
        allow_dis[IDX_CLK]  = !stg_on[IDX_SYNC];
        allow_en[IDX_SYNC]  = stg_sts[IDX_CLK];
        allow_dis[IDX_SYNC] = !(disp_out || disp_pend);
    end

    for (genvar i = 0; i < N_BASIC; i++) begin : g_stage
        lcd_stage_ctl u_stg (
            .clk         (clk),
            .rst_n       (rst_n),
            .en_i        (en_req[i]),
            .dis_i       (dis_req[i]),
            .allow_en_i  (allow_en[i]),
            .allow_dis_i (allow_dis[i]),
            .on_o        (stg_on[i]),
            .sts_o       (stg_sts[i])
        );
    end

    lcd_disp_guard #(.GW(GW)) u_disp (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_req[IDX_DISP]),
        .dis_i      (dis_req[IDX_DISP]),
        .sync_on_i  (stg_on[IDX_SYNC]),
        .sync_sts_i (stg_sts[IDX_SYNC]),
        .frame_i    (frame_start),
        .guard_i    (guard_frames),
        .disp_o     (disp_out),
        .disp_sts_o (disp_sts),
        .pend_o     (disp_pend)
    );

    assign pclk_en  = stg_on[IDX_CLK];
    assign sync_run = stg_on[IDX_SYNC];
    assign status   = {disp_sts, stg_sts[IDX_SYNC], stg_sts[IDX_CLK]};

    AST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        sync_run |-> pclk_en); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && !pclk_en)); // R1
endmodule

// File: tb/sim_lcd_pwr_seq.sv
module sim_lcd_pwr_seq;
    localparam int GW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    en_req = '0;
    logic [2:0]    dis_req = '0;
    logic [GW-1:0] guard_frames = '0;
    logic          frame_start = 1'b0;
    logic          pclk_en, sync_run, disp_out;
    logic [2:0]    status;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    // Reference model state, written from the requirements.
    logic m_clk = 0, m_sync = 0, m_disp = 0, m_pend = 0;
    logic [2:0] m_st = '0;
    int m_cnt = 0;

    always #10 clk = ~clk;

    lcd_pwr_seq #(.GW(GW)) u0 (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .guard_frames(guard_frames), .frame_start(frame_start),
        .pclk_en(pclk_en), .sync_run(sync_run), .disp_out(disp_out),
        .status(status)
    );

    // Driver: one cycle of stimulus plus the expected state after the edge.
    task automatic cyc(input logic r, input logic [2:0] en, input logic [2:0] dis,
                       input logic fs, input int g, input string tag);
        logic n_clk, n_sync, n_disp, n_pend;
        int n_cnt;
        @(negedge clk);
        rst_n = r; en_req = en; dis_req = dis; frame_start = fs;
        guard_frames = GW'(g);
        n_clk = m_clk; n_sync = m_sync; n_disp = m_disp; n_pend = m_pend; n_cnt = m_cnt;
        if (!r) begin
            n_clk = 0; n_sync = 0; n_disp = 0; n_pend = 0; n_cnt = 0;
        end else begin
            if (dis[0] && !m_sync) n_clk = 0;
            else if (en[0] && !dis[0]) n_clk = 1;
            if (dis[1] && !m_disp && !m_pend) n_sync = 0;
            else if (en[1] && !dis[1] && m_st[0]) n_sync = 1;
            if (dis[2] || !m_sync) begin
                n_pend = 0; n_disp = 0; n_cnt = 0;
            end else begin
                if (en[2] && m_st[1]) n_pend = 1;
                if (m_pend && fs && !m_disp) begin
                    if (m_cnt == g) n_disp = 1;
                    else n_cnt = m_cnt + 1;
                end
            end
        end
        m_st = r ? {m_disp, m_sync, m_clk} : 3'b000;
        m_clk = n_clk; m_sync = n_sync; m_disp = n_disp; m_pend = n_pend; m_cnt = n_cnt;
        exp_q.push_back({m_st, m_disp, m_sync, m_clk});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input int g, input string tag);
        for (int i = 0; i < n; i++) cyc(1, 3'b000, 3'b000, 0, g, tag);
    endtask

    // Monitor: compare design outputs with the scoreboard after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [5:0] e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {status, disp_out, sync_run, pclk_en};
                total++;
                if (a !== e) begin
                    bad++;
                    $display("FAIL %s: got st=%b d/s/c=%b expected st=%b d/s/c=%b",
                             t, a[5:3], a[2:0], e[5:3], e[2:0]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(0, 3'b000, 3'b000, 0, 0, "R1 reset");
        cyc(0, 3'b111, 3'b000, 1, 0, "R1 reset");
        cyc(1, 3'b000, 3'b000, 0, 0, "R1 after reset");
        cyc(1, 3'b010, 3'b000, 0, 0, "R3 sync without clock");
        cyc(1, 3'b100, 3'b000, 1, 0, "R5 disp without sync");
        cyc(1, 3'b001, 3'b000, 0, 0, "R2 clock up");
        cyc(1, 3'b000, 3'b000, 0, 0, "R2 clock status");
        cyc(1, 3'b001, 3'b001, 0, 0, "R11 both on clock");
        idle(2, 0, "R11 clock stays off");
        cyc(1, 3'b001, 3'b000, 0, 0, "R2 clock up again");
        cyc(1, 3'b010, 3'b000, 0, 0, "R3 sync while status lags");
        idle(1, 0, "R2 status settles");
        cyc(1, 3'b010, 3'b000, 0, 0, "R4 sync up");
        cyc(1, 3'b100, 3'b000, 1, 0, "R5 disp while sync status lags");
        cyc(1, 3'b000, 3'b001, 1, 0, "R10 clock off blocked");
        idle(2, 2, "R5 no disp");
        cyc(1, 3'b100, 3'b000, 0, 2, "R6 disp request g=2");
        cyc(1, 3'b000, 3'b000, 1, 2, "R6 frame 1");
        idle(2, 2, "R6 wait");
        cyc(1, 3'b000, 3'b000, 1, 2, "R6 frame 2");
        cyc(1, 3'b000, 3'b000, 0, 2, "R6 gap");
        cyc(1, 3'b000, 3'b000, 1, 2, "R6 frame 3 raises disp");
        idle(2, 2, "R6 disp status");
        cyc(1, 3'b000, 3'b010, 0, 2, "R9 sync off blocked by disp");
        cyc(1, 3'b010, 3'b010, 0, 2, "R11 both on sync blocked");
        cyc(1, 3'b000, 3'b100, 1, 2, "R8 disp off");
        idle(2, 0, "R8 stays off");
        cyc(1, 3'b100, 3'b000, 0, 0, "R7 disp request g=0");
        cyc(1, 3'b000, 3'b000, 1, 0, "R7 first frame");
        idle(1, 0, "R7 status");
        cyc(1, 3'b000, 3'b100, 0, 0, "R8 disp off again");
        cyc(1, 3'b100, 3'b000, 0, 5, "R9 pending request g=5");
        cyc(1, 3'b000, 3'b000, 1, 5, "R9 frame");
        cyc(1, 3'b000, 3'b010, 0, 5, "R9 sync off blocked by pending");
        cyc(1, 3'b000, 3'b000, 1, 5, "R9 frame");
        cyc(1, 3'b000, 3'b100, 0, 5, "R8 cancel pending");
        for (int i = 0; i < 8; i++)
            cyc(1, 3'b000, 3'b000, i[0], 5, "R8 no disp after cancel");
        cyc(1, 3'b000, 3'b010, 0, 5, "R12 sync off");
        idle(1, 5, "R12 sync status");
        cyc(1, 3'b000, 3'b001, 0, 5, "R12 clock off");
        idle(2, 5, "R12 all off");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule